// File: doc/BRIEF.md
# Read-Cycle Wait-State and Step Controller

This block decides, once per machine cycle, whether a small 8-bit processor bus sequencer may move on to its next bus cycle or must repeat the current one. A slow memory or a short DMA takeover pulls the ready input low. The block then holds the sequencer on read cycles only and keeps the address and cycle-kind outputs frozen for the whole wait. A write cycle always completes. If ready was low during a write, the block remembers this and adds one forced wait to the next read.

A built-in stepping helper can also hold the machine at every opcode fetch. A one-cycle step pulse lets exactly one opcode fetch through, which lets a debugger run the program one instruction at a time. Ready is sampled on the clock edge that ends each cycle. The sequencer advances at that edge only when `advance_o` is high during the cycle.

Top module: `rdy_stall_ctrl`

## Requirements
- R1: After reset, the block is in the flowing state. The frozen outputs follow `addr_i`, `wr_i` and `fetch_i` directly, and a read with ready high advances.
- R2: A read cycle (the frozen `wr_o` is 0) with `rdy_i` low drives `advance_o` low.
- R3: Once a read is held, it stays held while ready is low. It advances in the first cycle in which ready is high and no pending deferral exists.
- R4: In every cycle after the first cycle of a hold, `addr_o`, `wr_o` and `fetch_o` equal the values shown in the cycle where the hold began, whatever the inputs do.
- R5: A write cycle (`wr_o` is 1) always has `advance_o` high, even when ready is low.
- R6: If ready is low during a write, the next read cycle is held for at least one cycle, even when ready is high. Only that one read is affected.
- R7: A deferred hold is kept across any number of back-to-back writes until a read consumes it.
- R8: With `step_mode_i` high, `step_rdy_o` is low while `fetch_o` is high and no step token is held.
- R9: A one-cycle `step_pulse_i` grants a token. The token lets exactly one opcode fetch advance and is then spent, so the next opcode fetch is held again.
- R10: With `step_mode_i` low, `step_rdy_o` stays high.
- R11: The internal ready is the AND of `rdy_i` and `step_rdy_o`. An opcode fetch held by the stepping helper does not advance even with `rdy_i` high.
- R12: A DMA takeover that holds ready low for two consecutive read cycles gives exactly two held cycles, then an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one machine cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy_i | input | 1 | External ready; low requests a wait |
| wr_i | input | 1 | Sequencer marks the current cycle as a write |
| fetch_i | input | 1 | Sequencer marks an opcode fetch cycle |
| addr_i | input | ADDR_W | Sequencer address for the current cycle |
| step_mode_i | input | 1 | Turns on instruction stepping |
| step_pulse_i | input | 1 | One-cycle request to release one instruction |
| advance_o | output | 1 | Sequencer may move on at the coming edge |
| addr_o | output | ADDR_W | Address held stable through waits |
| wr_o | output | 1 | Write flag held stable through waits |
| fetch_o | output | 1 | Opcode-fetch flag held stable through waits |
| step_rdy_o | output | 1 | Ready drive from the stepping helper |

## Verification
The assertions assume that the cycle kind seen by the block is the frozen one, and that ready and the step pulse are synchronous levels sampled once per cycle. They make no assumption about whether the sequencer honours `advance_o`. The stimulus therefore changes `addr_i`, `wr_i` and `fetch_i` freely during holds, which shows that the outputs come from the frozen copy. Random stimulus biases ready high so that waits, deferrals and step releases mix, and directed sequences cover the two-cycle DMA hold, back-to-back writes and a single step release.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   // Wait-state tracker: flowing, holding a read, or a deferred hold pending
   typedef enum logic [1:0] {
      ST_FLOW  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_DEFER = 2'd2
   } stall_st_e;
endpackage

// File: rtl/rsc_cyc_hold.sv
module rsc_cyc_hold #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cyc_i,
   input  logic         adv_i,
   input  logic         hold_i,
   output logic [W-1:0] cyc_o
);
   logic [W-1:0] lat_q;

   // During a hold, the captured copy replaces the live sequencer view
   assign cyc_o = hold_i ? lat_q : cyc_i;

   always_ff @(posedge clk) begin
      if (!rst_n)      lat_q <= '0;
      else if (!adv_i) lat_q <= cyc_o;
   end

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> (cyc_o == $past(cyc_o))); // R4
endmodule

// File: rtl/rsc_stall_core.sv
module rsc_stall_core
   import rsc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_i,
   input  logic wr_i,
   output logic adv_o,
   output logic hold_o
);
   stall_st_e st_q, st_d;

   always_comb begin
      adv_o = wr_i | (rdy_i & (st_q != ST_DEFER));
      if (wr_i)
         st_d = (!rdy_i || st_q == ST_DEFER) ? ST_DEFER : ST_FLOW;
      else
         st_d = adv_o ? ST_FLOW : ST_WAIT;
   end

   assign hold_o = (st_q == ST_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_FLOW;
      else        st_q <= st_d;
   end

   AST_DEFER_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !rdy_i) ##1 !wr_i |-> !adv_o); // R6
   AST_STALL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_o) ##1 (rdy_i && !wr_i) |-> adv_o); // R3
   AST_DEFER_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i) ##1 (!wr_i && rdy_i) |-> adv_o); // R6
endmodule

// File: rtl/rsc_step_gate.sv
module rsc_step_gate #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_i,
   input  logic pulse_i,
   input  logic fetch_i,
   input  logic adv_i,
   output logic step_rdy_o
);
   generate
      if (ENABLE) begin : g_on
         logic tok_q;

         assign step_rdy_o = !(mode_i && fetch_i && !tok_q);

         always_ff @(posedge clk) begin
            if (!rst_n)                tok_q <= 1'b0;
            else if (pulse_i)          tok_q <= 1'b1;
            else if (fetch_i && adv_i) tok_q <= 1'b0;
         end

         AST_ONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_i && adv_i && !pulse_i) |=> (!(mode_i && fetch_i) || !step_rdy_o)); // R9
         AST_MODE_OFF_READY: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_i |-> step_rdy_o); // R10
      end else begin : g_off
         logic unused_w;
         assign unused_w   = &{1'b0, clk, rst_n, mode_i, pulse_i, fetch_i, adv_i};
         assign step_rdy_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rdy_stall_ctrl.sv
module rdy_stall_ctrl #(
   parameter int ADDR_W      = 16,
   parameter bit STEP_HELPER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rdy_i,
   input  logic              wr_i,
   input  logic              fetch_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              step_mode_i,
   input  logic              step_pulse_i,
   output logic              advance_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o,
   output logic              fetch_o,
   output logic              step_rdy_o
);
   localparam int CYC_W = ADDR_W + 2;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("rdy_stall_ctrl: ADDR_W must lie in 1..32");
      end
   endgenerate

   logic [CYC_W-1:0] cyc_live, cyc_held;
   logic             hold_w, rdy_eff;

   assign cyc_live = {addr_i, wr_i, fetch_i};
   assign {addr_o, wr_o, fetch_o} = cyc_held;
   assign rdy_eff  = rdy_i & step_rdy_o;

   rsc_cyc_hold #(.W(CYC_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .cyc_i(cyc_live), .adv_i(advance_o),
      .hold_i(hold_w), .cyc_o(cyc_held));

   rsc_stall_core u_core (
      .clk(clk), .rst_n(rst_n), .rdy_i(rdy_eff), .wr_i(wr_o),
      .adv_o(advance_o), .hold_o(hold_w));

   rsc_step_gate #(.ENABLE(STEP_HELPER)) u_step (
      .clk(clk), .rst_n(rst_n), .mode_i(step_mode_i), .pulse_i(step_pulse_i),
      .fetch_i(fetch_o), .adv_i(advance_o), .step_rdy_o(step_rdy_o));

   AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> advance_o); // R5
   AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !advance_o |=> (addr_o == $past(addr_o))); // R4
   AST_STEP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_rdy_o && !wr_o) |-> !advance_o); // R11
endmodule

// File: tb/rdy_stall_ctrl_tb_top.sv
module rdy_stall_ctrl_tb_top;
   localparam int AW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rdy_i = 1'b1, wr_i = 1'b0, fetch_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic step_mode_i = 1'b0, step_pulse_i = 1'b0;
   logic advance_o, wr_o, fetch_o, step_rdy_o;
   logic [AW-1:0] addr_o;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // model state: 0 flowing, 1 holding, 2 deferred
   int m_st = 0;
   logic [AW-1:0] m_laddr = '0;
   logic m_lwr = 1'b0, m_lfetch = 1'b0, m_tok = 1'b0;

   always #4 clk = ~clk;

   rdy_stall_ctrl #(.ADDR_W(AW), .STEP_HELPER(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .rdy_i(rdy_i), .wr_i(wr_i), .fetch_i(fetch_i),
      .addr_i(addr_i), .step_mode_i(step_mode_i), .step_pulse_i(step_pulse_i),
      .advance_o(advance_o), .addr_o(addr_o), .wr_o(wr_o), .fetch_o(fetch_o),
      .step_rdy_o(step_rdy_o));

   function automatic logic exp_step_rdy(input logic f, input logic mode);
      return !(mode && f && !m_tok);
   endfunction

   function automatic logic exp_adv(input logic w, input logic reff);
      return w ? 1'b1 : (reff && m_st != 2);
   endfunction

   task automatic tick(input logic r, input logic w, input logic f,
                       input logic [AW-1:0] a, input logic mode,
                       input logic p, input string tag);
      logic hold, e_wr, e_f, e_sr, e_adv, reff;
      logic [AW-1:0] e_a;
      bit bad;
      @(negedge clk);
      rdy_i = r; wr_i = w; fetch_i = f; addr_i = a;
      step_mode_i = mode; step_pulse_i = p;
      #1;
      hold  = (m_st == 1);
      e_a   = hold ? m_laddr  : a;
      e_wr  = hold ? m_lwr    : w;
      e_f   = hold ? m_lfetch : f;
      e_sr  = exp_step_rdy(e_f, mode);
      reff  = r & e_sr;
      e_adv = exp_adv(e_wr, reff);
      n_vec++;
      bad = 0;
      if (advance_o !== e_adv) begin bad = 1;
         $display("FAIL %s advance_o act=%0b exp=%0b", tag, advance_o, e_adv); end
      if (addr_o !== e_a) begin bad = 1;
         $display("FAIL %s addr_o act=%h exp=%h", tag, addr_o, e_a); end
      if (wr_o !== e_wr) begin bad = 1;
         $display("FAIL %s wr_o act=%0b exp=%0b", tag, wr_o, e_wr); end
      if (fetch_o !== e_f) begin bad = 1;
         $display("FAIL %s fetch_o act=%0b exp=%0b", tag, fetch_o, e_f); end
      if (step_rdy_o !== e_sr) begin bad = 1;
         $display("FAIL %s step_rdy_o act=%0b exp=%0b", tag, step_rdy_o, e_sr); end
      if (bad) n_bad++;
      // advance the model to the state after the coming edge
      if (!e_adv) begin m_laddr = e_a; m_lwr = e_wr; m_lfetch = e_f; end
      if (p) m_tok = 1'b1;
      else if (e_f && e_adv) m_tok = 1'b0;
      if (e_wr) m_st = (!reff || m_st == 2) ? 2 : 0;
      else      m_st = e_adv ? 0 : 1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=timeout exp=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1581));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: flowing read after reset
      tick(1, 0, 0, 16'h1234, 0, 0, "R1");
      // R2 R12: DMA holds ready low for two reads, inputs change meanwhile (R4)
      tick(0, 0, 0, 16'h2000, 0, 0, "R2");
      tick(0, 1, 1, 16'h5555, 0, 0, "R12 R4");
      tick(1, 1, 0, 16'h6666, 0, 0, "R3 R4");
      tick(1, 0, 0, 16'h2001, 0, 0, "R3");
      // R5 write with ready low passes, R7 second write keeps the deferral
      tick(0, 1, 0, 16'h3000, 0, 0, "R5");
      tick(1, 1, 0, 16'h3001, 0, 0, "R7");
      tick(1, 0, 0, 16'h3002, 0, 0, "R6");
      tick(1, 0, 1, 16'h7777, 0, 0, "R6 R4");
      tick(1, 0, 0, 16'h3003, 0, 0, "R6");
      // R8 R11: stepping holds the fetch even with ready high
      tick(1, 0, 1, 16'h4000, 1, 0, "R8 R11");
      tick(1, 0, 1, 16'h4000, 1, 0, "R8 R11");
      tick(1, 0, 1, 16'h4000, 1, 1, "R9");
      tick(1, 0, 1, 16'h4000, 1, 0, "R9");
      tick(1, 0, 0, 16'h4001, 1, 0, "R9");
      tick(1, 0, 1, 16'h4002, 1, 0, "R9");
      tick(1, 0, 1, 16'h4002, 1, 0, "R9");
      // R10: stepping off releases the fetch
      tick(1, 0, 1, 16'h4002, 0, 0, "R10");
      tick(1, 0, 1, 16'h4003, 0, 0, "R10");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic r, w, f, m, p;
         r = ($urandom % 4) != 0;
         w = ($urandom % 4) == 0;
         f = !w && (($urandom % 3) == 0);
         m = ($urandom % 8) < 3;
         p = ($urandom % 6) == 0;
         tick(r, w, f, AW'($urandom), m, p, "R2 R3 R4 R5 R6 R9 R11");
      end
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule